// File: doc/BRIEF.md
# Run-Length Infrared Transmitter with Carrier Modulation

This block turns a stream of run-length samples into an infrared drive waveform. Each sample is one byte. Bit 7 says whether the interval is a mark (pulse) or a gap (space), and bits 6:0 give its length in sample-period units. The host keeps two sample slots filled. It writes slot 0, then slot 1, then slot 0 again, and so on. The block plays the samples back to back in that same order. When a sample finishes, the block raises a one-cycle done strobe so the host can queue the next sample into the slot that has just freed up.

During a mark, the output follows a carrier. The carrier period and high time are programmed in 500 ns units, and a polarity bit inverts the waveform. A period of zero gives a steady (unmodulated) mark. During a gap, the output is low. Two emitter pins carry the same waveform, and each pin is gated by its own bit of a transmitter mask.

If the next slot is still empty when the current sample ends, the output drops to idle and a sticky underrun flag goes high. The flag stays high until the next sample starts. The flag also marks the normal end of a transmission.

Top module: `ir_burst_tx`

## Requirements
- R1: After reset, `ir_out`, `done_irq` and `underrun` are 0. The configuration then holds period 32, high time 16, polarity 0 and mask 2'b11.
- R2: A write is accepted only when `wr_slot` equals the expected slot and that slot is empty. The expected slot is 0 after reset and toggles on each accepted write. Any other write is ignored.
- R3: A sample byte has the mark flag in bit 7 and the count in bits 6:0. The sample lasts count × SAMPLE_CYC clock cycles, and a count of 0 lasts as long as a count of 1.
- R4: From idle, a write to slot 0 presented before clock edge E takes effect on the output in the cycle that follows edge E+1.
- R5: While the next slot is full, each sample starts in the cycle right after the previous one ends, with no gap. Samples are taken in the order they were written.
- R6: `done_irq` is high for exactly the first cycle after each sample ends.
- R7: When a sample ends and the next slot is empty, `ir_out` goes to 0 and `underrun` rises in that same cycle. `underrun` stays high until the next sample starts.
- R8: Within a run of consecutive mark samples, k counts cycles from the first cycle of the run, starting at 0. The carrier phase is (k / HALF_US_CYC) mod period, and the carrier is high while the phase is below the high time. The phase runs on without a break from one mark sample to the next.
- R9: A programmed high time of 0 behaves as a high time of 1.
- R10: With period 0, the output is steadily high for the whole mark.
- R11: The polarity bit inverts the carrier during marks. During gaps the output is always 0.
- R12: `ir_out[i]` is the mark waveform ANDed with mask bit i.
- R13: A cycle with `cfg_we` high loads period, high time, polarity and mask together. Configuration is changed only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Sample write strobe |
| wr_slot | input | 1 | Target slot of the write |
| wr_data | input | 8 | Sample: bit 7 mark flag, bits 6:0 count |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_period | input | 7 | Carrier period in 500 ns units, 0 = unmodulated |
| cfg_high | input | 7 | Carrier high time in 500 ns units |
| cfg_pol | input | 1 | Carrier polarity invert |
| cfg_mask | input | 2 | Per-emitter enable |
| ir_out | output | 2 | Emitter drive pins |
| done_irq | output | 1 | One-cycle strobe at the end of each sample |
| underrun | output | 1 | Sticky flag: a sample ended with no successor queued |

## Verification
The assertions assume that SAMPLE_CYC is at least 2, so two done strobes can never land on adjacent cycles. They also assume that configuration is written only while no mark is being played. The stimulus changes configuration only after a burst has fully drained. It refills a slot only in the cycle of a done strobe, which keeps every write aimed at the expected, empty slot, except for one deliberate wrong-slot write. Random bursts draw counts from a range that includes zero, and they draw periods and high times that include zero and high times longer than the period.

// File: rtl/irtx_pkg.sv
// Package: shared sample format for the run-length IR transmitter.
// Assumes an 8-bit sample byte: mark flag on top, count below it.
package irtx_pkg;
    localparam int CNT_W = 7;
    localparam int SMP_W = CNT_W + 1;

    typedef struct packed {
        logic             mark;
        logic [CNT_W-1:0] count;
    } sample_t;
endpackage

// File: rtl/irtx_slots.sv
// Module: two-slot sample buffer and playback sequencer.
// A slot is filled by an accepted host write and freed when its sample is
// loaded for playback. Each sample plays for max(count,1) units of
// SAMPLE_CYC clocks. Assumes SAMPLE_CYC >= 1.
module irtx_slots
    import irtx_pkg::*;
#(
    parameter int SAMPLE_CYC = 4
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_slot,
    input  sample_t    wr_data,
    output logic       mark_on,
    output logic       done_irq,
    output logic       underrun
);
    localparam int UW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
    localparam logic [UW-1:0] UNIT_LAST = UW'(SAMPLE_CYC - 1);

    logic             wr_ptr_q, rd_ptr_q, active_q, mark_q;
    logic [CNT_W-1:0] left_q;
    logic [UW-1:0]    unit_q;
    logic [1:0]       full_vec;
    sample_t          slot_data [2];
    logic             accept, unit_end, last_unit, load_now;
    sample_t          next_smp;

    assign accept    = wr_en && (wr_slot == wr_ptr_q) && !full_vec[wr_ptr_q];
    assign unit_end  = active_q && (unit_q == UNIT_LAST);
    assign last_unit = unit_end && (left_q == CNT_W'(1));
    assign load_now  = full_vec[rd_ptr_q] && (!active_q || last_unit);
    assign next_smp  = slot_data[rd_ptr_q];

    for (genvar g = 0; g < 2; g++) begin : g_slot
        logic    full_q;
        sample_t data_q;

        // Fill on accepted write, empty when loaded for playback.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q <= 1'b0;
                data_q <= '0;
            end else if (accept && (wr_ptr_q == 1'(g))) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (load_now && (rd_ptr_q == 1'(g))) begin
                full_q <= 1'b0;
            end
        end

        assign full_vec[g]  = full_q;
        assign slot_data[g] = data_q;
    end

    // Expected write slot toggles on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_ptr_q <= 1'b0;
        else if (accept) wr_ptr_q <= ~wr_ptr_q;
    end

    // Playback: load, count units, end or chain into the next sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mark_q   <= 1'b0;
            left_q   <= '0;
            unit_q   <= '0;
            rd_ptr_q <= 1'b0;
            underrun <= 1'b0;
        end else if (load_now) begin
            active_q <= 1'b1;
            mark_q   <= next_smp.mark;
            left_q   <= (next_smp.count == '0) ? CNT_W'(1) : next_smp.count;
            unit_q   <= '0;
            rd_ptr_q <= ~rd_ptr_q;
            underrun <= 1'b0;
        end else if (last_unit) begin
            active_q <= 1'b0;
            mark_q   <= 1'b0;
            underrun <= 1'b1;
        end else if (unit_end) begin
            unit_q <= '0;
            left_q <= left_q - CNT_W'(1);
        end else if (active_q) begin
            unit_q <= unit_q + UW'(1);
        end
    end

    // One-cycle strobe after each finished sample.
    always_ff @(posedge clk) begin
        if (!rst_n) done_irq <= 1'b0;
        else        done_irq <= last_unit;
    end

    assign mark_on = active_q && mark_q;
endmodule

// File: rtl/irtx_carrier.sv
// Module: carrier generator in 500 ns units.
// Counters restart while run is low, so every run of marks starts at
// phase 0. A period of 0 yields a steady high level; a high time of 0
// acts as 1. Assumes HALF_US_CYC clocks make 500 ns.
module irtx_carrier #(
    parameter int HALF_US_CYC = 2,
    parameter int CAR_W       = 7
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CAR_W-1:0] period,
    input  logic [CAR_W-1:0] high,
    input  logic             pol,
    output logic             level
);
    localparam int PW = (HALF_US_CYC > 1) ? $clog2(HALF_US_CYC) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(HALF_US_CYC - 1);

    logic [PW-1:0]    pre_q;
    logic [CAR_W-1:0] phase_q;
    logic [CAR_W-1:0] high_eff;

    assign high_eff = (high == '0) ? CAR_W'(1) : high;

    // Prescale to 500 ns steps and advance the phase modulo period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q   <= '0;
            phase_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q   <= '0;
            phase_q <= (phase_q >= period - CAR_W'(1)) ? '0 : phase_q + CAR_W'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    assign level = (period == '0) ? 1'b1 : ((phase_q < high_eff) ^ pol);
endmodule

// File: rtl/irtx_emit.sv
// Module: per-emitter output gating.
// Each pin carries the carrier level during marks when its mask bit is set.
module irtx_emit #(
    parameter int NUM_EMIT = 2
)(
    input  logic                level,
    input  logic                mark_on,
    input  logic [NUM_EMIT-1:0] mask,
    output logic [NUM_EMIT-1:0] pins
);
    for (genvar g = 0; g < NUM_EMIT; g++) begin : g_pin
        assign pins[g] = mask[g] & mark_on & level;
    end
endmodule

// File: rtl/ir_burst_tx.sv
// Module: top of the run-length IR transmitter.
// Holds the configuration registers (reset to defaults) and joins the
// slot sequencer, carrier generator and emitter gates. Assumes the
// configuration is written only while idle.
module ir_burst_tx
    import irtx_pkg::*;
#(
    parameter int SAMPLE_CYC  = 4,
    parameter int HALF_US_CYC = 2,
    parameter int CAR_W       = 7,
    parameter int NUM_EMIT    = 2,
    parameter int DEF_PERIOD  = 32,
    parameter int DEF_HIGH    = 16
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_slot,
    input  logic [SMP_W-1:0]    wr_data,
    input  logic                cfg_we,
    input  logic [CAR_W-1:0]    cfg_period,
    input  logic [CAR_W-1:0]    cfg_high,
    input  logic                cfg_pol,
    input  logic [NUM_EMIT-1:0] cfg_mask,
    output logic [NUM_EMIT-1:0] ir_out,
    output logic                done_irq,
    output logic                underrun
);
    logic [CAR_W-1:0]    period_q, high_q;
    logic                pol_q;
    logic [NUM_EMIT-1:0] mask_q;
    logic                mark_on, level;

    // Configuration registers with their reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= CAR_W'(DEF_PERIOD);
            high_q   <= CAR_W'(DEF_HIGH);
            pol_q    <= 1'b0;
            mask_q   <= '1;
        end else if (cfg_we) begin
            period_q <= cfg_period;
            high_q   <= cfg_high;
            pol_q    <= cfg_pol;
            mask_q   <= cfg_mask;
        end
    end

    irtx_slots #(.SAMPLE_CYC(SAMPLE_CYC)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (sample_t'(wr_data)),
        .mark_on  (mark_on),
        .done_irq (done_irq),
        .underrun (underrun)
    );

    irtx_carrier #(.HALF_US_CYC(HALF_US_CYC), .CAR_W(CAR_W)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (mark_on),
        .period (period_q),
        .high   (high_q),
        .pol    (pol_q),
        .level  (level)
    );

    irtx_emit #(.NUM_EMIT(NUM_EMIT)) u_emit (
        .level   (level),
        .mark_on (mark_on),
        .mask    (mask_q),
        .pins    (ir_out)
    );
endmodule

// File: rtl/irtx_chk.sv
// Module: assertion checker bound to ir_burst_tx.
// Assumes SAMPLE_CYC >= 2 for the strobe-spacing property.
module irtx_chk #(
    parameter int SAMPLE_CYC = 4,
    parameter int NUM_EMIT   = 2,
    parameter int CAR_W      = 7
)(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_EMIT-1:0] ir_out,
    input logic                done_irq,
    input logic                underrun,
    input logic                mark_on,
    input logic [NUM_EMIT-1:0] mask,
    input logic [CAR_W-1:0]    period
);
    a_r11_space_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mark_on |-> ir_out == '0);

    a_r12_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_out & ~mask) == '0);

    a_r7_underrun_idle: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> ir_out == '0);

    a_r7_underrun_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> done_irq);

    a_r10_unmod_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_on && period == '0) |-> ir_out == mask);

    if (SAMPLE_CYC > 1) begin : g_irq
        a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            done_irq |=> !done_irq);
    end
endmodule

bind ir_burst_tx irtx_chk #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .NUM_EMIT   (NUM_EMIT),
    .CAR_W      (CAR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_out   (ir_out),
    .done_irq (done_irq),
    .underrun (underrun),
    .mark_on  (mark_on),
    .mask     (mask_q),
    .period   (period_q)
);

// File: tb/sim_ir_burst_tx.sv
module sim_ir_burst_tx;
    localparam int SC = 4;
    localparam int HC = 2;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_slot = 1'b0, cfg_we = 1'b0, cfg_pol = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] cfg_period = '0, cfg_high = '0;
    logic [1:0] cfg_mask = '0;
    wire  [1:0] ir_out;
    wire        done_irq, underrun;

    int   checks = 0, fails = 0, cyc = 0;
    bit   exp_slot = 1'b0;
    int   m_per = 32, m_high = 16;
    bit   m_pol = 1'b0;
    logic [1:0] m_mask = 2'b11;
    logic [7:0] smp [16];
    int   nsmp = 0;

    ir_burst_tx #(.SAMPLE_CYC(SC), .HALF_US_CYC(HC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_data(wr_data), .cfg_we(cfg_we), .cfg_period(cfg_period),
        .cfg_high(cfg_high), .cfg_pol(cfg_pol), .cfg_mask(cfg_mask),
        .ir_out(ir_out), .done_irq(done_irq), .underrun(underrun)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R5 watchdog: cycles=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int units(logic [7:0] s);
        return (s[6:0] == 7'd0) ? 1 : int'(s[6:0]);
    endfunction

    function automatic bit car_lvl(int k);
        int ph, h;
        if (m_per == 0) return 1'b1;
        ph = (k / HC) % m_per;
        h  = (m_high == 0) ? 1 : m_high;
        return (ph < h) ^ m_pol;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int per, int hi, bit pol, logic [1:0] mk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_period = per[6:0]; cfg_high = hi[6:0];
        cfg_pol = pol; cfg_mask = mk;
        @(negedge clk);
        cfg_we = 1'b0;
        m_per = per; m_high = hi; m_pol = pol; m_mask = mk;
    endtask

    // Plays smp[0..nsmp-1], refilling on each done strobe, and compares
    // every cycle with the waveform computed from the requirements.
    task automatic run_burst(string req);
        int ends [16];
        int total = 0, nxt = 2, k = 0, seg;
        bit prev_p = 1'b0, p, e_irq, e_ur;
        int e_out;
        int f_out = -1, a_out = 0, x_out = 0;
        int f_irq = -1, a_irq = 0, x_irq = 0;
        int f_ur = -1, a_ur = 0, x_ur = 0;
        for (int i = 0; i < nsmp; i++) begin
            total += units(smp[i]) * SC;
            ends[i] = total;
        end
        @(negedge clk);
        wr_en = 1'b1; wr_slot = exp_slot; wr_data = smp[0]; exp_slot = ~exp_slot;
        @(negedge clk);
        if (nsmp > 1) begin
            wr_slot = exp_slot; wr_data = smp[1]; exp_slot = ~exp_slot;
        end else begin
            wr_en = 1'b0;
        end
        for (int rel = 0; rel < total + 4; rel++) begin
            @(negedge clk);
            wr_en = 1'b0;
            seg = -1;
            for (int i = 0; i < nsmp; i++)
                if (seg < 0 && rel < ends[i]) seg = i;
            p = (seg >= 0) && smp[seg][7];
            if (p) k = prev_p ? k + 1 : 0;
            prev_p = p;
            e_out = p ? int'(m_mask & {2{car_lvl(k)}}) : 0;
            e_irq = 1'b0;
            for (int i = 0; i < nsmp; i++)
                if (rel == ends[i]) e_irq = 1'b1;
            e_ur = (rel >= total);
            if (f_out < 0 && int'(ir_out) != e_out) begin
                f_out = rel; a_out = int'(ir_out); x_out = e_out;
            end
            if (f_irq < 0 && done_irq != e_irq) begin
                f_irq = rel; a_irq = int'(done_irq); x_irq = int'(e_irq);
            end
            if (f_ur < 0 && underrun != e_ur) begin
                f_ur = rel; a_ur = int'(underrun); x_ur = int'(e_ur);
            end
            if (e_irq && nxt < nsmp) begin
                wr_en = 1'b1; wr_slot = exp_slot; wr_data = smp[nxt];
                nxt++; exp_slot = ~exp_slot;
            end
        end
        check(req, $sformatf("ir_out first diff at cycle %0d", f_out), a_out, x_out);
        check("R6", $sformatf("done_irq first diff at cycle %0d", f_irq), a_irq, x_irq);
        check("R7", $sformatf("underrun first diff at cycle %0d", f_ur), a_ur, x_ur);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check("R1", "ir_out in reset", int'(ir_out), 0);
        check("R1", "done_irq in reset", int'(done_irq), 0);
        check("R1", "underrun in reset", int'(underrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 defaults and R8 carrier: long mark under period 32 / high 16
        nsmp = 3; smp[0] = 8'hA8; smp[1] = 8'h02; smp[2] = 8'h81;
        run_burst("R1");

        // R4 start timing with a single short mark
        nsmp = 1; smp[0] = 8'h83;
        run_burst("R4");

        // R13 and R12: load new configuration, only emitter 0 enabled
        set_cfg(5, 2, 1'b0, 2'b01);
        nsmp = 4; smp[0] = 8'h8C; smp[1] = 8'h03; smp[2] = 8'h87; smp[3] = 8'h01;
        run_burst("R13");

        // R3 zero count and R8 carrier continuing across adjacent marks
        nsmp = 4; smp[0] = 8'h80; smp[1] = 8'h83; smp[2] = 8'h00; smp[3] = 8'h85;
        run_burst("R3");

        // R9 high time of zero
        set_cfg(6, 0, 1'b0, 2'b11);
        nsmp = 2; smp[0] = 8'h89; smp[1] = 8'h02;
        run_burst("R9");

        // R10 unmodulated output
        set_cfg(0, 3, 1'b0, 2'b11);
        nsmp = 3; smp[0] = 8'h84; smp[1] = 8'h01; smp[2] = 8'h82;
        run_burst("R10");

        // R11 polarity inversion with emitter 1 only
        set_cfg(4, 1, 1'b1, 2'b10);
        nsmp = 3; smp[0] = 8'h86; smp[1] = 8'h04; smp[2] = 8'h83;
        run_burst("R11");

        // R2: a write to the wrong slot must not start or queue anything
        @(negedge clk);
        wr_en = 1'b1; wr_slot = ~exp_slot; wr_data = 8'h85;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (8) @(negedge clk);
        check("R2", "ir_out after wrong-slot write", int'(ir_out), 0);
        check("R2", "underrun after wrong-slot write", int'(underrun), 1);
        nsmp = 1; smp[0] = 8'h82;
        run_burst("R2");

        // R5: random bursts under random configurations
        for (int b = 0; b < 8; b++) begin
            set_cfg(int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                    1'($urandom_range(0, 1)), 2'($urandom_range(1, 3)));
            nsmp = int'($urandom_range(2, 8));
            for (int i = 0; i < nsmp; i++)
                smp[i] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 20))};
            run_burst("R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule